// File: doc/BRIEF.md
# Self-timed program/erase engine with read-status polling

This block stands in for the internal timing engine of a byte-programmable non-volatile array. A program request carries a target address, the byte being loaded and the byte currently stored at that address; an erase request covers the whole array. Once a request is accepted, the engine counts a fixed number of clock cycles for that kind of operation. It pulls an active-low ready/busy output low for that whole interval. At the end it issues a one-cycle commit strobe that tells the array what to write.

While an operation runs, host reads are not served from the array. Bit 7 of the read data carries a polling flag: for a program it is the inverse of the loaded byte's bit 7 at the target address. Bit 6 carries a toggle flag that inverts after every completed read access. Software can therefore detect the end of the operation by polling either bit, or by watching the ready/busy line. When reset is low, any running operation is dropped without a commit and the read-data enable is forced off.

Top module: `pe_status_engine`

## Requirements
- R1: A start request accepted while idle drives `rdy_bsy_no` low from the next cycle for exactly PROG_CYCLES cycles (program) or ERASE_CYCLES cycles (erase).
- R2: `commit_o` is high for exactly one cycle: the first cycle in which `rdy_bsy_no` is high again. `commit_erase_o` is 1 when the finished operation was an erase and 0 when it was a program.
- R3: A program commit presents the latched address on `commit_addr_o` and the stored byte ANDed with the loaded byte on `commit_data_o`. An erase commit presents address 0 and all ones.
- R4: A start request that arrives while busy is ignored. It does not lengthen the busy interval, does not cause an extra commit, and does not change the latched address or data.
- R5: When program and erase are requested in the same idle cycle, the erase is performed.
- R6: While busy, read-data bit 7 is the inverse of the loaded byte's bit 7 during a program read at the latched address. It is 0 during an erase. During a program read at any other address it is the array's bit 7.
- R7: While busy, read-data bit 6 is a toggle flag that is 0 when the operation starts and inverts after each read access ends (`rd_req_i` falls). Bits 5..0 pass the array data through.
- R8: While idle, `rd_data_o` equals `arr_data_i` on every bit, and repeated reads do not change it.
- R9: `rd_oe_o` follows `rd_req_i` while `rst_ni` is high. Reset low forces `rd_oe_o` to 0 and `rdy_bsy_no` to 1, and an aborted operation never produces a commit.
- R10: A start request presented in the commit cycle is accepted, so the next operation turns the busy line low again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts the operation |
| prog_start_i | input | 1 | Program start request |
| erase_start_i | input | 1 | Erase start request |
| ld_addr_i | input | AW | Program target address |
| ld_data_i | input | DW | Byte loaded for programming |
| old_data_i | input | DW | Byte currently stored at the target |
| rd_req_i | input | 1 | Read access active |
| rd_addr_i | input | AW | Read address |
| arr_data_i | input | DW | Array data at the read address |
| rd_data_o | output | DW | Read data, or polling status while busy |
| rd_oe_o | output | 1 | Read data drive enable (0 = high impedance) |
| rdy_bsy_no | output | 1 | Ready (1) / busy (0), open-drain style |
| commit_o | output | 1 | One-cycle array update strobe |
| commit_erase_o | output | 1 | Commit is an erase |
| commit_addr_o | output | AW | Commit address |
| commit_data_o | output | DW | Commit data |

## Verification
Two events can land in the same cycle: the commit of one operation and the acceptance of the next. The bench provokes this by chaining every run, presenting the next start request in the same cycle it samples the commit. It judges the result by the commit fields of the finishing operation and by the busy line falling in the very next cycle with the new duration. The bench also injects a start in the middle of an operation, in the same cycle as a read, to show that the toggle flag, the latched target and the busy length are not disturbed.

// File: rtl/pe_status_pkg.sv
package pe_status_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2
  } op_e;
endpackage

// File: rtl/pe_op_timer.sv
module pe_op_timer
  import pe_status_pkg::*;
#(
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_prog_i,
  input  logic req_erase_i,
  output logic accept_o,
  output logic busy_o,
  output op_e  op_o,
  output logic done_o
);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PLOAD = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ELOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  op_e           op_q;

  assign accept_o = !busy_q && (req_prog_i || req_erase_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      op_q   <= OP_NONE;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        op_q   <= req_erase_i ? OP_ERASE : OP_PROG;  // erase wins
        cnt_q  <= req_erase_i ? ELOAD : PLOAD;
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign op_o   = op_q;
  assign done_o = done_q;

  a_r1_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  a_r4_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && (req_prog_i || req_erase_i)) |=> $stable(op_q));
endmodule

// File: rtl/pe_toggle_track.sv
module pe_toggle_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic busy_i,
  input  logic rd_i,
  output logic tog_o
);
  logic rd_q, tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_i;
      if (clr_i)                         tog_q <= 1'b0;
      else if (busy_i && rd_q && !rd_i)  tog_q <= ~tog_q;  // access ended
    end
  end

  assign tog_o = tog_q;

  a_r7_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !clr_i) |=> $stable(tog_q));

  a_r7_cleared_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !tog_q);
endmodule

// File: rtl/pe_poll_mux.sv
module pe_poll_mux
  import pe_status_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          busy_i,
  input  op_e           op_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic [DW-1:0] lat_ld_i,
  input  logic          tog_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  always_comb begin
    rd_data_o = arr_data_i;
    if (busy_i) begin
      rd_data_o[TOG_BIT] = tog_i;
      if (op_i == OP_ERASE)            rd_data_o[POLL_BIT] = 1'b0;
      else if (rd_addr_i == lat_addr_i) rd_data_o[POLL_BIT] = ~lat_ld_i[POLL_BIT];
    end
  end
endmodule

// File: rtl/pe_status_engine.sv
module pe_status_engine
  import pe_status_pkg::*;
#(
  parameter int AW           = 20,
  parameter int DW           = 8,
  parameter int PROG_CYCLES  = 16,
  parameter int ERASE_CYCLES = 200
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_start_i,
  input  logic          erase_start_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [DW-1:0] old_data_i,
  input  logic          rd_req_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_oe_o,
  output logic          rdy_bsy_no,
  output logic          commit_o,
  output logic          commit_erase_o,
  output logic [AW-1:0] commit_addr_o,
  output logic [DW-1:0] commit_data_o
);
  logic          accept, busy, done, tog;
  op_e           op;
  logic [AW-1:0] lat_addr_q;
  logic [DW-1:0] lat_ld_q, lat_res_q;

  pe_op_timer #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .req_prog_i (prog_start_i),
    .req_erase_i(erase_start_i),
    .accept_o   (accept),
    .busy_o     (busy),
    .op_o       (op),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_addr_q <= '0;
      lat_ld_q   <= '0;
      lat_res_q  <= '0;
    end else if (accept) begin
      lat_addr_q <= ld_addr_i;
      lat_ld_q   <= ld_data_i;
      lat_res_q  <= old_data_i & ld_data_i;  // bits only clear
    end
  end

  pe_toggle_track u_tog (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .busy_i(busy),
    .rd_i  (rd_req_i),
    .tog_o (tog)
  );

  pe_poll_mux #(.AW(AW), .DW(DW)) u_mux (
    .busy_i    (busy),
    .op_i      (op),
    .lat_addr_i(lat_addr_q),
    .lat_ld_i  (lat_ld_q),
    .tog_i     (tog),
    .rd_addr_i,
    .arr_data_i,
    .rd_data_o
  );

  assign rd_oe_o        = rst_ni & rd_req_i;
  assign rdy_bsy_no     = ~busy;
  assign commit_o       = done;
  assign commit_erase_o = done && (op == OP_ERASE);
  assign commit_addr_o  = (op == OP_ERASE) ? '0 : lat_addr_q;
  assign commit_data_o  = (op == OP_ERASE) ? '1 : lat_res_q;

  a_r2_commit_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_bsy_no) |-> commit_o);

  a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);

  a_r4_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(lat_addr_q) && $stable(lat_ld_q) && $stable(lat_res_q)));

  a_r3_erase_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_erase_o |-> (commit_data_o == '1 && commit_o));
endmodule

// File: tb/sim_pe_status_engine.sv
module sim_pe_status_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PR = 6;
  localparam int ER = 20;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          prog_start_i = 1'b0, erase_start_i = 1'b0;
  logic [AW-1:0] ld_addr_i = '0, rd_addr_i = '0;
  logic [DW-1:0] ld_data_i = '0, old_data_i = '0, arr_data_i;
  logic          rd_req_i = 1'b0;
  logic [DW-1:0] rd_data_o, commit_data_o;
  logic          rd_oe_o, rdy_bsy_no, commit_o, commit_erase_o;
  logic [AW-1:0] commit_addr_o;

  int checks = 0, errors = 0;

  assign arr_data_i = rd_addr_i ^ 8'hA5;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pe_status_engine #(.AW(AW), .DW(DW), .PROG_CYCLES(PR), .ERASE_CYCLES(ER)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts at a negedge; returns at the negedge where the commit is visible
  task automatic run_op(input bit p, input bit e, input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] o, input bit inject, input string stag);
    int cnt = 0, nrd = 0, k = 0;
    logic [7:0] exp_rd;
    prog_start_i = p; erase_start_i = e;
    ld_addr_i = a; ld_data_i = d; old_data_i = o;
    @(negedge clk_i);
    prog_start_i = 0; erase_start_i = 0;
    chk(rdy_bsy_no == 1'b0, stag, rdy_bsy_no, 0);
    while (rdy_bsy_no == 1'b0 && k < 1000) begin
      cnt++;
      if (inject && k == 2) begin  // R4: start while busy
        prog_start_i = 1; erase_start_i = 1; ld_addr_i = ~a; ld_data_i = ~d;
      end else begin
        prog_start_i = 0; erase_start_i = 0;
      end
      if (k % 2 == 0) begin
        rd_addr_i = (k % 4 == 0) ? a : (a ^ 8'h01);
        rd_req_i = 1;
        #1;
        exp_rd = arr_data_i;
        exp_rd[6] = nrd[0];
        if (e) exp_rd[7] = 1'b0;
        else if (rd_addr_i == a) exp_rd[7] = ~d[7];
        chk(rd_data_o[7] == exp_rd[7], "R6", rd_data_o, exp_rd);
        chk(rd_data_o[6:0] == exp_rd[6:0], "R7", rd_data_o, exp_rd);
        chk(rd_oe_o == 1'b1, "R9", rd_oe_o, 1);
        nrd++;
      end else begin
        rd_req_i = 0;
      end
      k++;
      @(negedge clk_i);
    end
    rd_req_i = 0; prog_start_i = 0; erase_start_i = 0;
    chk(cnt == (e ? ER : PR), "R1", cnt, e ? ER : PR);
    chk(commit_o == 1'b1, "R2", commit_o, 1);
    chk(commit_erase_o == e, "R2/R5", commit_erase_o, e);
    chk(commit_addr_o == (e ? 8'h00 : a), "R3", commit_addr_o, e ? 8'h00 : a);
    chk(commit_data_o == (e ? 8'hFF : (o & d)), "R3", commit_data_o, e ? 8'hFF : (o & d));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    logic [7:0] first;
    rd_req_i = 1;
    #2;
    chk(rd_oe_o == 1'b0, "R9", rd_oe_o, 0);
    chk(rdy_bsy_no == 1'b1, "R9", rdy_bsy_no, 1);
    chk(commit_o == 1'b0, "R2", commit_o, 0);
    rd_req_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R8: idle reads pass array data, unchanged by repeated reads
    rd_addr_i = 8'h3C; rd_req_i = 1; #1;
    first = rd_data_o;
    chk(rd_data_o == arr_data_i, "R8", rd_data_o, arr_data_i);
    @(negedge clk_i); rd_req_i = 0;
    @(negedge clk_i); rd_req_i = 1; #1;
    chk(rd_data_o == first, "R8", rd_data_o, first);
    @(negedge clk_i); rd_req_i = 0;
    @(negedge clk_i);

    // program sweep, back to back: every start lands in the previous commit cycle (R10)
    for (int i = 0; i < 16; i++) begin
      run_op(1'b1, 1'b0, 8'(i * 13 + 2), 8'(i * 17) ^ 8'h3C, 8'(i * 29 + 7), (i % 3 == 0),
             (i == 0) ? "R1" : "R10");
    end
    run_op(1'b0, 1'b1, 8'h40, 8'h00, 8'h00, 1'b1, "R10");
    run_op(1'b1, 1'b1, 8'h41, 8'h12, 8'hFF, 1'b0, "R5");
    run_op(1'b1, 1'b0, 8'h80, 8'h7F, 8'hFF, 1'b1, "R10");
    @(negedge clk_i);

    // R8 after completion: no more toggling
    rd_addr_i = 8'h80; rd_req_i = 1; #1;
    chk(rd_data_o == arr_data_i, "R8", rd_data_o, arr_data_i);
    @(negedge clk_i); rd_req_i = 0;
    @(negedge clk_i); rd_req_i = 1; #1;
    chk(rd_data_o == arr_data_i, "R8", rd_data_o, arr_data_i);
    @(negedge clk_i); rd_req_i = 0;

    // R9: abort erase with reset
    erase_start_i = 1;
    @(negedge clk_i); erase_start_i = 0;
    repeat (5) @(negedge clk_i);
    rst_ni = 0; rd_req_i = 1; #1;
    chk(rd_oe_o == 1'b0, "R9", rd_oe_o, 0);
    chk(rdy_bsy_no == 1'b1, "R9", rdy_bsy_no, 1);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1; rd_req_i = 0;
    seen = 0;
    for (int c = 0; c < ER + 5; c++) begin
      @(negedge clk_i);
      if (commit_o || !rdy_bsy_no) seen = 1;
    end
    chk(!seen, "R9", seen, 0);

    run_op(1'b1, 1'b0, 8'h55, 8'hF0, 8'h3C, 1'b0, "R1");
    @(negedge clk_i);
    chk(commit_o == 1'b0, "R2", commit_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule